// File: doc/BRIEF.md
# Parallel Link Bring-Up Controller

This block brings a parallel word-wide chip-to-chip link into service after reset and then supervises it. When reset is released it starts training with no further command. It sends a fixed training code to the far end, with a status code in every other word. It watches the received words and the deskew result from its own sampler. When alignment is reached it changes its status code from "not aligned" to "acknowledge". It then waits for the far end's acknowledge. After that both ends swap a configuration word that carries a 4-bit identity. Only when that exchange succeeds does the controller declare the link up.

In service, the controller counts cycles in which no valid word arrives. A long silence means the far end was reset or the cable was pulled, and the link is taken down. Each fault drives a status flag: training failure, configuration mismatch, or link-loss interrupt. Each flag holds, and the controller parks in a terminal error state. Only a full reset clears a flag or starts training again. The role parameter chooses whether this end acts as the master, which judges configuration and raises the interrupt, or as the slave.

Top module: `link_train_ctrl`

## Requirements
- R1: While `rst` is high, `tx_word_o` is 0x00, and `link_up_o`, `link_fail_o`, `cfg_err_o` and `link_err_irq_o` are all low.
- R2: On the first clock edge after reset is released, training starts with no other input. From that edge `tx_word_o` alternates between 0xA5 (training code) and 0x3C (not aligned), and 0xA5 comes first.
- R3: Training moves on only on an edge where `deskew_done_i` is high and `rx_valid_i` delivers one of 0xA5, 0x3C or 0xC3. From then on the status slot carries 0xC3 (acknowledge) instead of 0x3C. Deskew-done alone, or a training code alone, does not move training on.
- R4: After local alignment, the controller waits until a valid 0xC3 is received from the far end. On the edge that delivers it, `tx_word_o` becomes the configuration word: upper nibble 0x9, lower nibble `LOCAL_CFG`. The link never comes up before that.
- R5: In the configuration phase, a received word with upper nibble 0x9 and lower nibble equal to `LOCAL_CFG` raises `link_up_o` on that edge. While the link is up, `tx_word_o` is 0x00.
- R6: On a master, a received configuration word whose identity differs from `LOCAL_CFG` sets `cfg_err_o` on that edge. The link then never comes up until reset, even if a matching word follows.
- R7: The training window is the run of edges from entering training through the configuration phase. If the link is not up after `TRAIN_LIMIT` edges in that window, `link_fail_o` is set on edge `TRAIN_LIMIT`+1 after reset release.
- R8: While the link is up, `LOSS_LIMIT` (64) consecutive edges with `rx_valid_i` low drop `link_up_o` and set `link_err_irq_o` on the last of those edges. Any valid word within the run restarts the count.
- R9: After any fault, `link_up_o` stays low, `tx_word_o` stays 0x00, and every flag that was set stays set, whatever the inputs do. A reset clears them all.
- R10: A configuration word arriving on the very edge where the training window expires takes priority over the timeout. A mismatch sets only `cfg_err_o`, and a match brings the link up with `link_fail_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_word_i | input | 8 | Word received from the far end |
| rx_valid_i | input | 1 | Marks `rx_word_i` as holding a word |
| deskew_done_i | input | 1 | Local sampler reports a good sampling point |
| tx_word_o | output | 8 | Word to send to the far end |
| link_up_o | output | 1 | Link is trained and in service |
| link_fail_o | output | 1 | Sticky: training did not finish in time |
| cfg_err_o | output | 1 | Sticky: far-end configuration mismatch (master) |
| link_err_irq_o | output | 1 | Sticky: link lost while in service (master) |

## Verification
In the configuration phase, two events can land on the same clock edge. One is the arrival of the far end's configuration word. The other is the expiry of the training window. The bench counts edges from reset release and drives a deskewed bring-up into the configuration phase quickly. It then holds back the configuration word until the exact edge on which the window runs out, once with a mismatching identity and once with a matching one. It judges the outcome on the flags: a mismatch must set only the configuration flag, and a match must bring the link up with the failure flag clear.

// File: rtl/lt_pkg.sv
package lt_pkg;

    localparam int WORD_W = 8;
    localparam int CFG_W  = 4;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [CFG_W-1:0]  cfg_id_t;

    localparam word_t   CODE_TRAIN  = 8'hA5;
    localparam word_t   CODE_NALIGN = 8'h3C;
    localparam word_t   CODE_ACK    = 8'hC3;
    localparam word_t   CODE_IDLE   = 8'h00;
    localparam cfg_id_t CFG_TAG     = 4'h9;

    typedef enum logic [2:0] {
        ST_RESET,
        ST_TRAIN,
        ST_WAIT_ACK,
        ST_CFG_CHECK,
        ST_LINK_UP,
        ST_ERROR
    } lt_state_e;

    typedef enum logic [1:0] {
        ERR_NONE,
        ERR_FAIL,
        ERR_CFG,
        ERR_LOSS
    } err_kind_e;

    typedef struct packed {
        logic    train_code;
        logic    ack;
        logic    cfg;
        cfg_id_t cfg_id;
    } rx_info_t;

    function automatic word_t cfg_word(input cfg_id_t id);
        return {CFG_TAG, id};
    endfunction

    function automatic logic is_training_state(input lt_state_e st);
        return (st == ST_TRAIN) || (st == ST_WAIT_ACK) || (st == ST_CFG_CHECK);
    endfunction

endpackage

// File: rtl/lt_rx_decode.sv
module lt_rx_decode
    import lt_pkg::*;
(
    input  word_t    rx_word_i,
    input  logic     rx_valid_i,
    output rx_info_t info_o
);

    always_comb begin
        info_o            = '0;
        info_o.train_code = rx_valid_i &&
                            ((rx_word_i == CODE_TRAIN) ||
                             (rx_word_i == CODE_NALIGN) ||
                             (rx_word_i == CODE_ACK));
        info_o.ack        = rx_valid_i && (rx_word_i == CODE_ACK);
        info_o.cfg        = rx_valid_i && (rx_word_i[WORD_W-1 -: CFG_W] == CFG_TAG);
        info_o.cfg_id     = rx_word_i[CFG_W-1:0];
    end

endmodule

// File: rtl/lt_run_counter.sv
module lt_run_counter #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic clear_i,
    input  logic tick_i,
    output logic expired_o
);

    localparam int CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = tick_i && (cnt_q == LAST);

endmodule

// File: rtl/lt_tx_select.sv
module lt_tx_select
    import lt_pkg::*;
#(
    parameter cfg_id_t LOCAL_CFG = 4'h5
) (
    input  lt_state_e state_i,
    input  logic      phase_i,
    output word_t     tx_word_o
);

    always_comb begin
        unique case (state_i)
            ST_TRAIN:     tx_word_o = phase_i ? CODE_NALIGN : CODE_TRAIN;
            ST_WAIT_ACK:  tx_word_o = phase_i ? CODE_ACK    : CODE_TRAIN;
            ST_CFG_CHECK: tx_word_o = cfg_word(LOCAL_CFG);
            default:      tx_word_o = CODE_IDLE;
        endcase
    end

endmodule

// File: rtl/link_train_ctrl.sv
module link_train_ctrl
    import lt_pkg::*;
#(
    parameter bit      IS_MASTER   = 1'b1,
    parameter cfg_id_t LOCAL_CFG   = 4'h5,
    parameter int      TRAIN_LIMIT = 256,
    parameter int      LOSS_LIMIT  = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] rx_word_i,
    input  logic       rx_valid_i,
    input  logic       deskew_done_i,
    output logic [7:0] tx_word_o,
    output logic       link_up_o,
    output logic       link_fail_o,
    output logic       cfg_err_o,
    output logic       link_err_irq_o
);

    lt_state_e fsm_q, fsm_nxt;
    err_kind_e err_kind;
    rx_info_t  rx_info;
    logic      phase_q;
    logic      train_tick, train_exp;
    logic      loss_tick, loss_clear, loss_exp;
    logic      fail_q, cfg_q;

    lt_rx_decode u_decode (
        .rx_word_i  (rx_word_i),
        .rx_valid_i (rx_valid_i),
        .info_o     (rx_info)
    );

    assign train_tick = is_training_state(fsm_q);

    lt_run_counter #(.LIMIT(TRAIN_LIMIT)) u_train_win (
        .clk       (clk),
        .rst       (rst),
        .clear_i   (!train_tick),
        .tick_i    (train_tick),
        .expired_o (train_exp)
    );

    assign loss_tick  = (fsm_q == ST_LINK_UP) && !rx_valid_i;
    assign loss_clear = (fsm_q != ST_LINK_UP) || rx_valid_i;

    lt_run_counter #(.LIMIT(LOSS_LIMIT)) u_loss_win (
        .clk       (clk),
        .rst       (rst),
        .clear_i   (loss_clear),
        .tick_i    (loss_tick),
        .expired_o (loss_exp)
    );

    always_comb begin
        fsm_nxt  = fsm_q;
        err_kind = ERR_NONE;
        unique case (fsm_q)
            ST_RESET: fsm_nxt = ST_TRAIN;
            ST_TRAIN: begin
                if (train_exp) begin
                    fsm_nxt  = ST_ERROR;
                    err_kind = ERR_FAIL;
                end else if (rx_info.train_code && deskew_done_i) begin
                    fsm_nxt = ST_WAIT_ACK;
                end
            end
            ST_WAIT_ACK: begin
                if (train_exp) begin
                    fsm_nxt  = ST_ERROR;
                    err_kind = ERR_FAIL;
                end else if (rx_info.ack) begin
                    fsm_nxt = ST_CFG_CHECK;
                end
            end
            ST_CFG_CHECK: begin
                if (rx_info.cfg) begin
                    if (!IS_MASTER || (rx_info.cfg_id == LOCAL_CFG)) begin
                        fsm_nxt = ST_LINK_UP;
                    end else begin
                        fsm_nxt  = ST_ERROR;
                        err_kind = ERR_CFG;
                    end
                end else if (train_exp) begin
                    fsm_nxt  = ST_ERROR;
                    err_kind = ERR_FAIL;
                end
            end
            ST_LINK_UP: begin
                if (loss_exp) begin
                    fsm_nxt  = ST_ERROR;
                    err_kind = ERR_LOSS;
                end
            end
            default: fsm_nxt = ST_ERROR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q   <= ST_RESET;
            phase_q <= 1'b0;
            fail_q  <= 1'b0;
            cfg_q   <= 1'b0;
        end else begin
            fsm_q   <= fsm_nxt;
            phase_q <= ((fsm_q == ST_TRAIN) || (fsm_q == ST_WAIT_ACK)) ? ~phase_q : 1'b0;
            if (err_kind == ERR_FAIL) fail_q <= 1'b1;
            if (err_kind == ERR_CFG)  cfg_q  <= 1'b1;
        end
    end

    generate
        if (IS_MASTER) begin : g_master_irq
            logic irq_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    irq_q <= 1'b0;
                end else if (err_kind == ERR_LOSS) begin
                    irq_q <= 1'b1;
                end
            end
            assign link_err_irq_o = irq_q;
        end else begin : g_slave_irq
            assign link_err_irq_o = 1'b0;
        end
    endgenerate

    lt_tx_select #(.LOCAL_CFG(LOCAL_CFG)) u_tx (
        .state_i   (fsm_q),
        .phase_i   (phase_q),
        .tx_word_o (tx_word_o)
    );

    assign link_up_o   = (fsm_q == ST_LINK_UP);
    assign link_fail_o = fail_q;
    assign cfg_err_o   = cfg_q;

    // R5
    up_after_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(link_up_o) |-> $past(fsm_q == ST_CFG_CHECK));

    // R5
    up_tx_idle_chk: assert property (@(posedge clk) disable iff (rst)
        link_up_o |-> (tx_word_o == CODE_IDLE));

    // R6
    cfg_err_no_up_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_err_o |-> !link_up_o);

    // R7
    window_end_chk: assert property (@(posedge clk) disable iff (rst)
        train_exp |=> (fsm_q == ST_ERROR) || (fsm_q == ST_LINK_UP));

    // R8
    irq_from_up_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(link_err_irq_o) |-> $past(link_up_o));

    // R9
    error_terminal_chk: assert property (@(posedge clk) disable iff (rst)
        (fsm_q == ST_ERROR) |=> (fsm_q == ST_ERROR));

    // R9
    fail_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        link_fail_o |=> link_fail_o);

    // R9
    cfg_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_err_o |=> cfg_err_o);

    // R9
    irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        link_err_irq_o |=> link_err_irq_o);

    // R10
    single_cause_chk: assert property (@(posedge clk) disable iff (rst)
        !(link_fail_o && cfg_err_o));

endmodule

// File: tb/link_train_ctrl_tb.sv
`timescale 1ns/1ps
module link_train_ctrl_tb;

    localparam int TRAIN_LIMIT = 256;
    localparam int LOSS_LIMIT  = 64;
    localparam logic [3:0] MY_CFG = 4'h5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] rx_word = 8'h00;
    logic       rx_valid = 1'b0;
    logic       deskew_done = 1'b0;
    logic [7:0] tx_word;
    logic       link_up, link_fail, cfg_err, link_irq;

    int checks = 0;
    int errors = 0;
    int edge_n = 0;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) edge_n <= 0;
        else     edge_n <= edge_n + 1;
    end

    link_train_ctrl #(
        .IS_MASTER   (1'b1),
        .LOCAL_CFG   (MY_CFG),
        .TRAIN_LIMIT (TRAIN_LIMIT),
        .LOSS_LIMIT  (LOSS_LIMIT)
    ) u_dut (
        .clk            (clk),
        .rst            (rst),
        .rx_word_i      (rx_word),
        .rx_valid_i     (rx_valid),
        .deskew_done_i  (deskew_done),
        .tx_word_o      (tx_word),
        .link_up_o      (link_up),
        .link_fail_o    (link_fail),
        .cfg_err_o      (cfg_err),
        .link_err_irq_o (link_irq)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; rx_word = 8'h00; rx_valid = 1'b0; deskew_done = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_edge(input int n);
        while (edge_n < n) @(negedge clk);
    endtask

    // Brings the link up: E2 aligned, E3 remote ack, E4 config match
    task automatic bring_up();
        do_reset();
        rx_valid = 1'b1; deskew_done = 1'b1; rx_word = 8'hA5;
        repeat (2) @(negedge clk);
        rx_word = 8'hC3;
        @(negedge clk);
        rx_word = {4'h9, MY_CFG};
        @(negedge clk);
        rx_word = 8'h00;
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(tx_word == 8'h00, "R1", "tx in reset", tx_word, 8'h00);
        check({link_up, link_fail, cfg_err, link_irq} == 4'b0, "R1", "flags in reset",
              {link_up, link_fail, cfg_err, link_irq}, 0);
    endtask

    task automatic t_train_start();
        do_reset();
        @(negedge clk);
        check(tx_word == 8'hA5, "R2", "first training word", tx_word, 8'hA5);
        @(negedge clk);
        check(tx_word == 8'h3C, "R2", "not-aligned slot", tx_word, 8'h3C);
        @(negedge clk);
        check(tx_word == 8'hA5, "R2", "training repeats", tx_word, 8'hA5);
    endtask

    task automatic t_alignment();
        bit saw_nalign;
        bit saw_ack;
        do_reset();
        rx_valid = 1'b1; rx_word = 8'hA5; deskew_done = 1'b0;
        saw_nalign = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (tx_word == 8'h3C) saw_nalign = 1'b1;
            if (tx_word == 8'hC3) saw_ack = 1'b1;
        end
        rx_word = 8'h55; deskew_done = 1'b1;
        saw_ack = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (tx_word == 8'hC3) saw_ack = 1'b1;
        end
        check(saw_nalign && !saw_ack, "R3", "no advance without both conditions",
              saw_ack, 0);
        rx_word = 8'hA5;
        saw_ack = 1'b0; saw_nalign = 1'b0;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            if (tx_word == 8'hC3) saw_ack = 1'b1;
            if (tx_word == 8'h3C) saw_nalign = 1'b1;
        end
        check(saw_ack && !saw_nalign, "R3", "ack in status slot after align", saw_ack, 1);
    endtask

    task automatic t_wait_remote_ack();
        bit bad;
        do_reset();
        rx_valid = 1'b1; deskew_done = 1'b1; rx_word = 8'hA5;
        bad = 1'b0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (link_up || tx_word[7:4] == 4'h9) bad = 1'b1;
        end
        check(!bad, "R4", "holds without remote ack", bad, 0);
        rx_word = 8'hC3;
        @(negedge clk);
        check(tx_word == {4'h9, MY_CFG}, "R4", "config word after ack", tx_word, {4'h9, MY_CFG});
        check(!link_up, "R4", "not up before config", link_up, 0);
    endtask

    task automatic t_link_up();
        bring_up();
        check(link_up, "R5", "link up on config match", link_up, 1);
        check(tx_word == 8'h00, "R5", "idle while up", tx_word, 8'h00);
        check(!link_fail && !cfg_err && !link_irq, "R5", "no flags when up",
              {link_fail, cfg_err, link_irq}, 0);
    endtask

    task automatic t_cfg_mismatch();
        do_reset();
        rx_valid = 1'b1; deskew_done = 1'b1; rx_word = 8'hA5;
        repeat (2) @(negedge clk);
        rx_word = 8'hC3;
        @(negedge clk);
        rx_word = 8'h97;
        @(negedge clk);
        check(cfg_err, "R6", "cfg_err on mismatch", cfg_err, 1);
        rx_word = {4'h9, MY_CFG};
        repeat (5) @(negedge clk);
        check(!link_up && cfg_err, "R6", "no link up after mismatch", link_up, 0);
    endtask

    task automatic t_train_timeout();
        do_reset();
        rx_valid = 1'b1; rx_word = 8'hA5; deskew_done = 1'b0;
        wait_edge(TRAIN_LIMIT);
        check(!link_fail, "R7", "no fail before window end", link_fail, 0);
        @(negedge clk);
        check(link_fail, "R7", "fail at window end", link_fail, 1);
        check(tx_word == 8'h00 && !link_up, "R7", "tx idle after fail", tx_word, 0);
    endtask

    task automatic t_link_loss();
        bring_up();
        rx_valid = 1'b0;
        repeat (LOSS_LIMIT - 1) @(negedge clk);
        check(link_up, "R8", "still up after 63 silent", link_up, 1);
        rx_valid = 1'b1;
        repeat (3) @(negedge clk);
        check(link_up && !link_irq, "R8", "valid word restarts count", link_up, 1);
        rx_valid = 1'b0;
        repeat (LOSS_LIMIT - 1) @(negedge clk);
        check(link_up, "R8", "up at 63 of second run", link_up, 1);
        @(negedge clk);
        check(!link_up, "R8", "down after 64 silent", link_up, 0);
        check(link_irq, "R8", "interrupt raised", link_irq, 1);
    endtask

    task automatic t_sticky();
        bit bad;
        bad = 1'b0;
        rx_valid = 1'b1; deskew_done = 1'b1;
        for (int i = 0; i < 24; i++) begin
            rx_word = (i % 3 == 0) ? 8'hA5 : (i % 3 == 1) ? 8'hC3 : {4'h9, MY_CFG};
            @(negedge clk);
            if (link_up || !link_irq || tx_word != 8'h00) bad = 1'b1;
        end
        check(!bad, "R9", "error state holds", bad, 0);
        do_reset();
        check(!link_irq && !link_fail && !cfg_err, "R9", "reset clears flags",
              {link_fail, cfg_err, link_irq}, 0);
    endtask

    task automatic t_same_edge(input bit match);
        do_reset();
        rx_valid = 1'b1; deskew_done = 1'b1; rx_word = 8'hA5;
        repeat (2) @(negedge clk);
        rx_word = 8'hC3;
        @(negedge clk);
        rx_word = 8'h00;
        wait_edge(TRAIN_LIMIT);
        check(!link_fail && !link_up, "R10", "still in config phase", link_fail, 0);
        rx_word = match ? {4'h9, MY_CFG} : 8'h97;
        @(negedge clk);
        if (match) begin
            check(link_up && !link_fail, "R10", "match wins over timeout",
                  {link_up, link_fail}, 2'b10);
        end else begin
            check(cfg_err && !link_fail, "R10", "mismatch wins over timeout",
                  {cfg_err, link_fail}, 2'b10);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset_state();
        t_train_start();
        t_alignment();
        t_wait_remote_ack();
        t_link_up();
        t_cfg_mismatch();
        t_train_timeout();
        t_link_loss();
        t_sticky();
        t_same_edge(1'b0);
        t_same_edge(1'b1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule